// File: doc/BRIEF.md
# Word-Serial Burst Event Transmitter

This block collects one-cycle event pulses from a two-dimensional grid of sources and sends them off chip as bursts of words. A burst serves one row. It starts with a word holding that row's index. One word follows for each pending column of the row, in ascending order. A reserved tail word closes the burst. Each word goes out on 1-of-4 coded data lines and completes a four-phase return-to-neutral handshake against a single acknowledge input. No request line and no clock travel with the data.

Rows with pending events are granted in round-robin order. The columns of a granted row are copied into a staging register in one cycle, and those flags are cleared. While one burst is on the wire, the next row is granted and staged, so the sequencer can start the next burst right after a tail word. Three word sources (row, column, tail) are each gated by the sequencer's state. They are combined with a bitwise OR, and the result is registered onto the link lines.

Top module: `evt_burst_tx`

## Requirements
- R1: After reset all link lines are low and stay low until an event is pulsed.
- R2: A link word is the 10-bit value {addr[8:0], tail}. Its bit pair 2g+1:2g drives lines 4g+3:4g as a one-hot code: value v raises line 4g+v, so 0 gives 0001, 1 gives 0010, 2 gives 0100 and 3 gives 1000. In a valid word every group has exactly one line high. The least significant group therefore carries the tail bit and addr[0].
- R3: A valid word holds unchanged until the acknowledge is high. The lines then return to all-low, and no new word appears while the acknowledge is still high.
- R4: A burst is a row word (addr = row index, tail = 0), then column words (addr = column index, tail = 0) in ascending column order, then one tail word (addr = 0, tail = 1).
- R5: A burst carries exactly the columns that were pending in its row when the row was granted. Each pulsed event is sent once, and no words appear once all pending events have been sent.
- R6: Rows are granted round robin. After reset row 0 has first priority. Afterwards the search starts at the row after the last granted one and wraps around.
- R7: An event pulsed at a position after its row was granted is kept, and it is sent in a later burst.
- R8: At most one of the row, column and tail word sources is non-neutral in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | ROWS*COLS | One-cycle event pulses; bit r*COLS+c marks row r, column c |
| link_ack | input | 1 | Asynchronous acknowledge from the receiver |
| link_data | output | 2*(ADDR_W+1) | 1-of-4 coded link lines, groups of four |

## Verification
The hardest case to reach is an event at a position whose row has just been captured and is still in flight. Losing it or duplicating it would both be silent failures. The bench waits until it has decoded the row word of that burst, which proves the capture has happened, and then pulses the same position again. It expects a second complete burst for that row. Round-robin order and column ordering are checked by injecting single, full and pseudo-random grid patterns while the link is idle. For each pattern the bench predicts the burst sequence from its own model of the grant pointer.

// File: rtl/evt_burst_pkg.sv
// Shared types and helpers for the burst event transmitter.
package evt_burst_pkg;

    // Sequencer phases: each word has a valid phase and a neutral phase.
    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW_V,
        S_ROW_N,
        S_COL_V,
        S_COL_N,
        S_TAIL_V,
        S_TAIL_N
    } seq_state_t;

    // Map a two-bit value to its 1-of-4 line code.
    function automatic logic [3:0] code4(input logic [1:0] v);
        return 4'b0001 << v;
    endfunction

endpackage

// File: rtl/evt_row_arb.sv
// Event flag store, round-robin row arbiter and next-row staging register.
// Assumes evt_set pulses are synchronous to clk. A grant happens only while
// staging is empty; the granted row's flags clear in that cycle, and a pulse
// arriving in the same cycle survives.
module evt_row_arb #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ROWS*COLS-1:0] evt_set,
    input  logic                 stg_take,
    output logic                 stg_full,
    output logic [ROW_W-1:0]     stg_row,
    output logic [COLS-1:0]      stg_cols
);
    logic [ROWS-1:0][COLS-1:0] flags_q, flags_d, set_m, clr_m;
    logic [ROWS-1:0]           row_any;
    logic [ROW_W-1:0]          ptr_q, gnt_row;
    logic                      gnt_ok, grant;

    // Unflatten event pulses and summarise each row.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            set_m[r]   = evt_set[r*COLS +: COLS];
            row_any[r] = |flags_q[r];
        end
    end

    // Round robin: first pending row after the pointer, wrapping.
    always_comb begin
        gnt_ok  = 1'b0;
        gnt_row = '0;
        for (int k = ROWS - 1; k >= 0; k--) begin
            if (row_any[(int'(ptr_q) + 1 + k) % ROWS]) begin
                gnt_ok  = 1'b1;
                gnt_row = ROW_W'((int'(ptr_q) + 1 + k) % ROWS);
            end
        end
    end

    assign grant = gnt_ok && !stg_full;

    // Next flag state: clear the captured row, then merge new pulses.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            clr_m[r]   = (grant && gnt_row == ROW_W'(r)) ? flags_q[r] : '0;
            flags_d[r] = (flags_q[r] & ~clr_m[r]) | set_m[r];
        end
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Staging register and grant pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_full <= 1'b0;
            stg_row  <= '0;
            stg_cols <= '0;
            ptr_q    <= ROW_W'(ROWS - 1);
        end else if (grant) begin
            stg_full <= 1'b1;
            stg_row  <= gnt_row;
            stg_cols <= flags_q[gnt_row];
            ptr_q    <= gnt_row;
        end else if (stg_take) begin
            stg_full <= 1'b0;
        end
    end

    // A pulse is present in the flags one cycle later (R7).
    for (genvar r = 0; r < ROWS; r++) begin : g_keep
        p_keep_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_m[r]) |=> ((flags_q[r] & $past(set_m[r])) == $past(set_m[r])));
    end

    // A staged row is not altered before the sequencer takes it (R5).
    p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_full && !stg_take) |=> (stg_full && $stable(stg_row) && $stable(stg_cols)));

endmodule

// File: rtl/evt_burst_seq.sv
// Burst sequencer with column latch and acknowledge synchroniser.
// Loads a staged row, walks its column latch lowest index first and ends
// with a tail word. Each word waits for ack high, then for ack low.
module evt_burst_seq
    import evt_burst_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int ROW_W = 3,
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ack,
    input  logic             stg_full,
    input  logic [ROW_W-1:0] stg_row,
    input  logic [COLS-1:0]  stg_cols,
    output logic             stg_take,
    output logic             drv_row,
    output logic             drv_col,
    output logic             drv_tail,
    output logic [ROW_W-1:0] row_idx,
    output logic [COL_W-1:0] col_idx
);
    seq_state_t      state_q;
    logic [COLS-1:0] cols_q;
    logic            ack_m, ack_s;

    // Two-flop synchroniser for the asynchronous acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) {ack_s, ack_m} <= 2'b00;
        else        {ack_s, ack_m} <= {ack_m, link_ack};
    end

    // Lowest pending column in the latch.
    always_comb begin
        col_idx = '0;
        for (int c = COLS - 1; c >= 0; c--)
            if (cols_q[c]) col_idx = COL_W'(c);
    end

    assign stg_take = stg_full && (state_q == S_IDLE || (state_q == S_TAIL_N && !ack_s));
    assign drv_row  = (state_q == S_ROW_V);
    assign drv_col  = (state_q == S_COL_V);
    assign drv_tail = (state_q == S_TAIL_V);

    // Phase sequencing and column latch updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cols_q  <= '0;
            row_idx <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (stg_take) begin
                    row_idx <= stg_row;
                    cols_q  <= stg_cols;
                    state_q <= S_ROW_V;
                end
                S_ROW_V:  if (ack_s)  state_q <= S_ROW_N;
                S_ROW_N:  if (!ack_s) state_q <= S_COL_V;
                S_COL_V: if (ack_s) begin
                    cols_q[col_idx] <= 1'b0;
                    state_q         <= S_COL_N;
                end
                S_COL_N: if (!ack_s) state_q <= (cols_q != '0) ? S_COL_V : S_TAIL_V;
                S_TAIL_V: if (ack_s)  state_q <= S_TAIL_N;
                S_TAIL_N: if (!ack_s) begin
                    if (stg_take) begin
                        row_idx <= stg_row;
                        cols_q  <= stg_cols;
                        state_q <= S_ROW_V;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // A word holds while the synchronised ack is low (R3).
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_row || drv_col || drv_tail) && !ack_s) |=> ($stable(state_q) && $stable(col_idx) && $stable(row_idx)));

    // A staged row handed over always has at least one column (R5).
    p_load_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stg_take |-> (stg_cols != '0));

endmodule

// File: rtl/evt_link_enc.sv
// One-hot link encoder. Builds a word per source (row, column, tail), gates
// each by its drive strobe, ORs them and registers the lines.
// Assumes at most one strobe is active per cycle.
module evt_link_enc
    import evt_burst_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int LINES  = 2 * (ADDR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_row,
    input  logic             drv_col,
    input  logic             drv_tail,
    input  logic [ROW_W-1:0] row_idx,
    input  logic [COL_W-1:0] col_idx,
    output logic [LINES-1:0] link_data
);
    localparam int GROUPS = (ADDR_W + 1) / 2;

    logic [2:0][ADDR_W:0]  word;
    logic [2:0]            drv;
    logic [2:0][LINES-1:0] src;
    logic [LINES-1:0]      merged;

    assign word[0] = {ADDR_W'(row_idx), 1'b0};
    assign word[1] = {ADDR_W'(col_idx), 1'b0};
    assign word[2] = {ADDR_W'(0), 1'b1};
    assign drv     = {drv_tail, drv_col, drv_row};

    // Per-source gated 1-of-4 encoding.
    for (genvar s = 0; s < 3; s++) begin : g_src
        always_comb begin
            src[s] = '0;
            if (drv[s])
                for (int g = 0; g < GROUPS; g++)
                    src[s][4*g +: 4] = code4(word[s][2*g +: 2]);
        end
    end

    assign merged = src[0] | src[1] | src[2];

    // Register the merged lines so the link sees clean transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) link_data <= '0;
        else        link_data <= merged;
    end

    // Only one source may be non-neutral at a time (R8).
    p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|src[2], |src[1], |src[0]}));

endmodule

// File: rtl/evt_burst_tx.sv
// Top of the word-serial burst event transmitter: flag store and row
// arbiter, burst sequencer, and 1-of-4 link encoder.
// Assumes ADDR_W is odd and wide enough for the row and column indices.
module evt_burst_tx #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int ADDR_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ROWS*COLS-1:0]       evt_set,
    input  logic                       link_ack,
    output logic [2*(ADDR_W+1)-1:0]    link_data
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int LINES  = 2 * (ADDR_W + 1);
    localparam int GROUPS = LINES / 4;

    logic             stg_full, stg_take;
    logic [ROW_W-1:0] stg_row, row_idx;
    logic [COLS-1:0]  stg_cols;
    logic             drv_row, drv_col, drv_tail;
    logic [COL_W-1:0] col_idx;

    evt_row_arb #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .stg_take(stg_take),
        .stg_full(stg_full), .stg_row(stg_row), .stg_cols(stg_cols)
    );

    evt_burst_seq #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .link_ack(link_ack),
        .stg_full(stg_full), .stg_row(stg_row), .stg_cols(stg_cols),
        .stg_take(stg_take), .drv_row(drv_row), .drv_col(drv_col),
        .drv_tail(drv_tail), .row_idx(row_idx), .col_idx(col_idx)
    );

    evt_link_enc #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .LINES(LINES)) u_enc (
        .clk(clk), .rst_n(rst_n), .drv_row(drv_row), .drv_col(drv_col),
        .drv_tail(drv_tail), .row_idx(row_idx), .col_idx(col_idx),
        .link_data(link_data)
    );

    // Every group is neutral or one-hot, and all groups agree on validity (R2).
    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        p_group_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(link_data[4*g +: 4]) && ((link_data != '0) -> (link_data[4*g +: 4] != 4'b0)));
    end

endmodule

// File: tb/test_evt_burst_tx.sv
module test_evt_burst_tx;
    localparam int ROWS = 4, COLS = 4, ADDR_W = 9;
    localparam int LINES = 2 * (ADDR_W + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ROWS*COLS-1:0] evt_set = '0;
    logic                 link_ack = 1'b0;
    logic [LINES-1:0]     link_data;

    int n_chk = 0, n_bad = 0, last_row = ROWS - 1;
    bit done = 0;

    evt_burst_tx #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) i_evt_burst_tx (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .link_ack(link_ack), .link_data(link_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Receive one word with a full four-phase handshake; checks R2 and R3.
    task automatic get_word(output int addr, output int tl);
        logic [LINES-1:0] d0;
        logic [ADDR_W:0]  w;
        while (link_data == '0) @(negedge clk);
        @(negedge clk);
        d0 = link_data;
        w  = '0;
        for (int g = 0; g < LINES / 4; g++) begin
            chk($countones(d0[4*g +: 4]) == 1, "R2 group one-hot", $countones(d0[4*g +: 4]), 1);
            for (int v = 0; v < 4; v++)
                if (d0[4*g + v]) w[2*g +: 2] = 2'(v);
        end
        repeat (4) @(negedge clk);
        chk(link_data == d0, "R3 word held before ack", int'(link_data[15:0]), int'(d0[15:0]));
        link_ack = 1'b1;
        while (link_data != '0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(link_data == '0, "R3 neutral while ack high", int'(link_data[15:0]), 0);
        link_ack = 1'b0;
        addr = int'(w[ADDR_W:1]);
        tl   = int'(w[0]);
    endtask

    // Expect one burst for row r with the given column set (R4, R5, R6).
    task automatic expect_burst(input int r, input logic [COLS-1:0] cols);
        int a, t;
        get_word(a, t);
        chk(a == r && t == 0, "R6 row word", a, r);
        for (int c = 0; c < COLS; c++) begin
            if (cols[c]) begin
                get_word(a, t);
                chk(a == c && t == 0, "R4 column word ascending", a, c);
            end
        end
        get_word(a, t);
        chk(a == 0 && t == 1, "R4 tail word", a * 2 + t, 1);
        last_row = r;
    endtask

    // Pulse a grid pattern while idle and check the predicted bursts.
    task automatic run_pattern(input logic [ROWS*COLS-1:0] p);
        int base;
        @(negedge clk) evt_set = p;
        @(negedge clk) evt_set = '0;
        base = last_row;
        for (int k = 1; k <= ROWS; k++) begin
            int r;
            r = (base + k) % ROWS;
            if (p[r*COLS +: COLS] != '0) expect_burst(r, p[r*COLS +: COLS]);
        end
        repeat (20) @(negedge clk);
        chk(link_data == '0, "R5 no extra words", int'(link_data[15:0]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        int a, t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: neutral after reset with no events.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(link_data == '0, "R1 neutral after reset", int'(link_data[15:0]), 0);
        end
        // Single events at every position.
        for (int b = 0; b < ROWS * COLS; b++) run_pattern((ROWS*COLS)'(1) << b);
        // Whole grid.
        run_pattern('1);
        // Pseudo-random grid patterns.
        lf = 16'hACE1;
        for (int i = 0; i < 48; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf != '0) run_pattern(lf);
        end
        // R7: same position pulsed again after its row was granted.
        @(negedge clk) evt_set = 16'h0040;
        @(negedge clk) evt_set = '0;
        get_word(a, t);
        chk(a == 1 && t == 0, "R7 first row word", a, 1);
        @(negedge clk) evt_set = 16'h0040;
        @(negedge clk) evt_set = '0;
        get_word(a, t);
        chk(a == 2 && t == 0, "R7 first column word", a, 2);
        get_word(a, t);
        chk(t == 1, "R7 first tail", t, 1);
        expect_burst(1, 4'b0100);
        repeat (20) @(negedge clk);
        chk(link_data == '0, "R7 event sent once more only", int'(link_data[15:0]), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule